// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Lower-Half Lock

This block models a 256-byte serial EEPROM that answers on a two-wire bus. A fast system clock samples the bus clock and data lines. The block finds the bus START and STOP conditions, shifts bytes in and out, and drives the data line low to acknowledge or to send a zero. The storage array lives in on-chip registers. It is arranged as sixteen pages of sixteen bytes.

A host selects the array with the device code 1010, followed by three bits that must equal the strap pins. It can then write one byte or a page of up to sixteen bytes, or read from any address and keep reading in order. Incoming write data waits in a one-page buffer. It is committed to the array only by a clean STOP. The commit starts a self-timed busy interval whose length in system clock cycles is a parameter. During that interval the block does not acknowledge its address.

A second device code, 0110, reaches a one-shot lock. Writing to it makes the lower half of the array permanently read-only.

Top module: `e2_eeprom`

## Requirements
- R1: An address byte is acknowledged (SDA pulled low during the 9th clock) only if bits 7:4 are 1010 and bits 3:1 equal `strap_i`. Bit 0 selects read (1) or write (0). Any other address byte is not acknowledged, and the rest of that transfer is ignored until the next START.
- R2: A write transfer has three bytes, each sent MSB first: the address byte, a word address, then one data byte. When the STOP ends it, the data byte is stored at the word address.
- R3: In a page write, each data byte goes to the current address. After each byte, the low 4 address bits step by one modulo 16 and the upper 4 bits stay fixed. When more than 16 bytes are sent, a later byte overwrites an earlier one in the same slot.
- R4: A random read sets the word address in a write transfer, then sends a repeated START and an address byte with bit 0 = 1. The block then returns the byte stored at that address.
- R5: Every byte the block transmits advances the word address by one, wrapping from 0xFF to 0x00. After a byte, a master acknowledge asks for the next one and a master no-acknowledge ends the read. A later read that sends no word address continues from the current counter.
- R6: A STOP that commits data starts a write cycle. For WRITE_CYCLES system clocks after it, the block does not acknowledge its address. After that it acknowledges again.
- R7: An address byte with bits 7:4 = 0110, strap match and bit 0 = 0 is acknowledged while the lock is clear. A STOP after at least the acknowledged address byte then sets the lock and starts a write cycle. Once the lock is set, data bytes aimed at 0x00–0x7F are acknowledged but not stored, while 0x80–0xFF still accept writes.
- R8: No bus operation clears the lock. Once it is set, the 0110 write address is not acknowledged. The 0110 address with bit 0 = 1 is never acknowledged.
- R9: A write transfer whose data bytes all target locked addresses starts no write cycle. The address is acknowledged right after its STOP.
- R10: A START or STOP that arrives part-way through a byte discards the whole write transfer. Memory is unchanged and no write cycle starts.
- R11: After reset, `sda_pull_o` is low, the lock is clear, no write cycle is running, and every array byte reads 0xFF.
- R12: The block changes SDA only while SCL is low. It releases SDA after the 8th bit of each byte it transmits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| strap_i | input | 3 | Device select straps compared with address bits 3:1 |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with the default 16-byte page (PAGE_W = 4), two synchronizer stages and a write cycle of 400 system clocks, and ties the straps to 101. The short write cycle makes it practical to fill all sixteen pages, sweep every address with wrapping sequential reads, and probe the address acknowledge both inside and after the busy window. The same configuration keeps the lock tests within reach, including the protected-page, mixed-half and aborted-transfer cases, each checked against a bench-side byte model.

// File: rtl/e2_pkg.sv
`timescale 1ns/1ps
package e2_pkg;
  localparam int E2_BYTE_W = 8;
  localparam logic [3:0] MEM_CODE  = 4'b1010;
  localparam logic [3:0] LOCK_CODE = 4'b0110;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} link_state_t;
  typedef enum logic [1:0] {P_DEV, P_WORD, P_WDATA, P_LOCK} rx_phase_t;
endpackage

// File: rtl/e2_bus_sampler.sv
`timescale 1ns/1ps
module e2_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sync, sda_sync;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[TOP-1:0], scl_i};
      sda_sync <= {sda_sync[TOP-1:0], sda_i};
      scl_prev <= scl_sync[TOP];
      sda_prev <= sda_sync[TOP];
    end
  end

  assign scl_lvl   = scl_sync[TOP];
  assign sda_lvl   = sda_sync[TOP];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  // data moving while the clock stays high marks a bus condition
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/e2_page_buffer.sv
`timescale 1ns/1ps
module e2_page_buffer #(
  parameter int PAGE_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           load,
  input  logic [PAGE_W-1:0]              slot,
  input  logic [BYTE_W-1:0]              din,
  output logic [(1<<PAGE_W)*BYTE_W-1:0]  data,
  output logic [(1<<PAGE_W)-1:0]         valid
);
  localparam int SLOTS = 1 << PAGE_W;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = load && (slot == PAGE_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[s]                 <= 1'b0;
        data[s*BYTE_W +: BYTE_W] <= '0;
      end else if (clear) begin
        valid[s] <= 1'b0;
      end else if (hit) begin
        valid[s]                 <= 1'b1;
        data[s*BYTE_W +: BYTE_W] <= din;
      end
    end
  end
endmodule

// File: rtl/e2_array.sv
`timescale 1ns/1ps
module e2_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-PAGE_W-1:0]       page,
  input  logic [(1<<PAGE_W)-1:0]         mask,
  input  logic [(1<<PAGE_W)*BYTE_W-1:0]  wdata,
  input  logic [ADDR_W-1:0]              raddr,
  output logic [BYTE_W-1:0]              rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      for (int c = 0; c < SLOTS; c++)
        if (mask[c]) mem[{page, PAGE_W'(c)}] <= wdata[c*BYTE_W +: BYTE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/e2_write_timer.sv
`timescale 1ns/1ps
module e2_write_timer #(
  parameter int CYCLES = 1500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= CW'(CYCLES);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/e2_eeprom.sv
`timescale 1ns/1ps
module e2_eeprom #(
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 1500000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o
);
  import e2_pkg::*;

  localparam int ADDR_W     = E2_BYTE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  // ---- arithmetic kept in functions ----
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], PAGE_W'(a[PAGE_W-1:0] + 1'b1)};
  endfunction

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic is_guarded(input logic [ADDR_W-1:0] a, input logic locked);
    return locked && !a[ADDR_W-1];
  endfunction

  function automatic logic dev_hit(input logic [7:0] b, input logic [3:0] code,
                                   input logic [2:0] strap);
    return (b[7:4] == code) && (b[3:1] == strap);
  endfunction

  // ---- bus sampling ----
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  e2_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  // ---- link state ----
  link_state_t         state;
  rx_phase_t           phase;
  logic [3:0]          bit_cnt;
  logic [7:0]          rx_sh, tx_sh;
  logic [ADDR_W-1:0]   word_addr;
  logic                rd_mode, mack, pull_q, lock_q;

  // named events for the checker
  logic byte_eval, dev_phase, at_boundary, byte_ack;
  logic commit_en, lock_set, buf_load, buf_clear, busy;
  logic arr_we;
  logic [PG_W-1:0]           arr_page;
  logic [PAGE_BYTES-1:0]     buf_valid;
  logic [PAGE_BYTES*8-1:0]   buf_data;
  logic [7:0]                rd_byte;

  assign dev_phase   = (phase == P_DEV);
  assign byte_eval   = (state == S_RX) && scl_fall && (bit_cnt == 4'd8);
  // a STOP/START at a byte boundary arrives right after one clock rise
  assign at_boundary = (state == S_RX) && (bit_cnt == 4'd1);

  always_comb begin
    byte_ack = 1'b1;
    if (dev_phase)
      byte_ack = !busy &&
                 (dev_hit(rx_sh, MEM_CODE, strap_i) ||
                  (dev_hit(rx_sh, LOCK_CODE, strap_i) && !rx_sh[0] && !lock_q));
  end

  assign buf_clear = start_det | stop_det;
  assign buf_load  = byte_eval && (phase == P_WDATA) && !is_guarded(word_addr, lock_q);
  assign commit_en = stop_det && at_boundary && (phase == P_WDATA) && (|buf_valid);
  assign lock_set  = stop_det && at_boundary && (phase == P_LOCK);
  assign arr_we    = commit_en;
  assign arr_page  = word_addr[ADDR_W-1:PAGE_W];

  e2_page_buffer #(.PAGE_W(PAGE_W), .BYTE_W(8)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear), .load(buf_load),
    .slot(word_addr[PAGE_W-1:0]), .din(rx_sh), .data(buf_data), .valid(buf_valid)
  );

  e2_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_W(8)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .page(arr_page), .mask(buf_valid),
    .wdata(buf_data), .raddr(word_addr), .rdata(rd_byte)
  );

  e2_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_en | lock_set), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= P_DEV;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      word_addr <= '0;
      rd_mode   <= 1'b0;
      mack      <= 1'b0;
      pull_q    <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      if (lock_set) lock_q <= 1'b1;
      if (start_det) begin
        state   <= S_RX;
        phase   <= P_DEV;
        bit_cnt <= '0;
        rd_mode <= 1'b0;
        pull_q  <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        phase  <= P_DEV;
        pull_q <= 1'b0;
      end else begin
        unique case (state)
          S_RX: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_eval) begin
              if (byte_ack) begin
                pull_q <= 1'b1;
                state  <= S_ACK;
              end else begin
                state  <= S_IDLE;
              end
              unique case (phase)
                P_DEV: begin
                  rd_mode <= rx_sh[0];
                  phase   <= (rx_sh[7:4] == LOCK_CODE) ? P_LOCK : P_WORD;
                end
                P_WORD: begin
                  word_addr <= rx_sh;
                  phase     <= P_WDATA;
                end
                P_WDATA: word_addr <= page_next(word_addr);
                default: ;
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_mode) begin
                tx_sh  <= rd_byte;
                pull_q <= ~rd_byte[7];
                state  <= S_TX;
              end else begin
                pull_q <= 1'b0;
                state  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                pull_q    <= 1'b0;
                word_addr <= seq_next(word_addr);
                state     <= S_MACK;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                pull_q <= ~tx_sh[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_lvl;
            if (scl_fall) begin
              if (mack) begin
                bit_cnt <= '0;
                tx_sh   <= rd_byte;
                pull_q  <= ~rd_byte[7];
                state   <= S_TX;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/e2_eeprom_checks.sv
`timescale 1ns/1ps
module e2_eeprom_checks #(
  parameter int PG_W       = 4,
  parameter int PAGE_BYTES = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_lvl,
  input logic                  sda_pull,
  input logic                  lock_q,
  input logic                  busy,
  input logic                  byte_eval,
  input logic                  dev_phase,
  input logic                  stop_det,
  input logic                  arr_we,
  input logic [PG_W-1:0]       arr_page,
  input logic [PAGE_BYTES-1:0] arr_mask
);
  p_busy_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_eval && dev_phase && busy) |=> !sda_pull);

  p_commit_starts_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> busy);

  p_guard_low_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && lock_q) |-> arr_page[PG_W-1]);

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  p_no_empty_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_mask != '0));

  p_stop_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  p_drive_while_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl);
endmodule

bind e2_eeprom e2_eeprom_checks #(.PG_W(PG_W), .PAGE_BYTES(PAGE_BYTES)) u_checks (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_pull(sda_pull_o),
  .lock_q(lock_q), .busy(busy), .byte_eval(byte_eval), .dev_phase(dev_phase),
  .stop_det(stop_det), .arr_we(arr_we), .arr_page(arr_page), .arr_mask(buf_valid)
);

// File: tb/test_e2_eeprom.sv
`timescale 1ns/1ps
module test_e2_eeprom;
  localparam int WC = 400;
  localparam int H  = 5;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mem [256];
  logic       exp_lock = 1'b0;
  logic [7:0] exp_ptr = 8'h00;
  logic [7:0] wbuf [32];

  always #2 clk = ~clk;

  e2_eeprom #(.PAGE_W(4), .WRITE_CYCLES(WC), .SYNC_STAGES(2)) i_e2_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(STRAP), .sda_pull_o(sda_pull)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    report();
  end

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(2); sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(2); sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    tick(2); sda_m = b; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    tick(2); sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2); b = sda_line; tick(H - H/2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic more, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~more);
  endtask

  function automatic logic [7:0] dev(input logic [3:0] code, input logic [2:0] s, input logic rd);
    return {code, s, rd};
  endfunction

  task automatic poll(output logic ack);
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b0), ack);
    bus_stop();
  endtask

  // write n bytes from wbuf starting at a0; model follows R3/R7
  task automatic do_write(input logic [7:0] a0, input int n, input string tag);
    logic ack;
    logic [7:0] a;
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b0), ack); check({tag, " address ack"}, ack, 1);
    send_byte(a0, ack);                     check({tag, " word ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check({tag, " data ack"}, ack, 1);
    end
    bus_stop();
    a = a0;
    for (int i = 0; i < n; i++) begin
      if (!(exp_lock && a < 8'h80)) exp_mem[a] = wbuf[i];
      a = {a[7:4], 4'(a[3:0] + 4'd1)};
    end
  endtask

  // random read of n bytes (R4), sequential advance with wrap (R5), bit order (R12)
  task automatic read_at(input logic [7:0] a0, input int n, input string tag);
    logic ack;
    logic [7:0] v;
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b0), ack); check({tag, " R4 address ack"}, ack, 1);
    send_byte(a0, ack);                     check({tag, " R4 word ack"}, ack, 1);
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b1), ack); check({tag, " R4 read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      check({tag, " R12 read data"}, v, exp_mem[8'(a0 + i)]);
    end
    bus_stop();
    exp_ptr = 8'(a0 + n);
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    tick(5);
    check("R11 pull low in reset", sda_pull, 0);
    rst_n = 1'b1;
    tick(10);
    check("R11 pull low after reset", sda_pull, 0);
    poll(ack); check("R11 idle device acks", ack, 1);

    // R1 address matching
    bus_start(); send_byte(dev(4'hA, 3'b011, 1'b0), ack); bus_stop();
    check("R1 strap mismatch nack", ack, 0);
    bus_start(); send_byte(dev(4'hB, STRAP, 1'b0), ack); bus_stop();
    check("R1 wrong code nack", ack, 0);
    bus_start(); send_byte(dev(4'h6, STRAP, 1'b1), ack); bus_stop();
    check("R8 lock read nack", ack, 0);
    read_at(8'h20, 2, "R11 blank");

    // fill the array page by page (R3) and probe the write cycle (R6)
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 16; i++) wbuf[i] = 8'((p * 16 + i) * 7 + 3);
      do_write(8'(p * 16), 16, "R3 fill");
      if (p == 0) begin
        poll(ack); check("R6 nack during write cycle", ack, 0);
        tick(WC + 20);
        poll(ack); check("R6 ack after write cycle", ack, 1);
      end else begin
        tick(WC + 20);
      end
    end
    read_at(8'h00, 257, "R5 full sweep wrap");

    // R2 byte writes at edge addresses
    begin
      logic [7:0] ad [5] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h42};
      logic [7:0] dv [5] = '{8'h5A, 8'hC3, 8'h01, 8'hFE, 8'h99};
      for (int k = 0; k < 5; k++) begin
        wbuf[0] = dv[k];
        do_write(ad[k], 1, "R2 byte write");
        tick(WC + 20);
        read_at(ad[k], 1, "R2 byte readback");
      end
    end

    // R3 page wrap with overwrite
    for (int i = 0; i < 20; i++) wbuf[i] = 8'(200 + i * 3);
    do_write(8'h35, 20, "R3 wrap");
    tick(WC + 20);
    read_at(8'h30, 16, "R3 wrap readback");

    // R5 current-address read continues at 0x40
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b1), ack); check("R5 current read ack", ack, 1);
    recv_byte(1'b1, v); check("R5 current read byte0", v, exp_mem[exp_ptr]);
    recv_byte(1'b0, v); check("R5 current read byte1", v, exp_mem[8'(exp_ptr + 1)]);
    bus_stop();

    // R10 STOP mid-byte
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b0), ack);
    send_byte(8'h10, ack);
    send_byte(8'hAA, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    poll(ack); check("R10 stop abort leaves device idle", ack, 1);
    read_at(8'h10, 2, "R10 stop abort memory");

    // R10 START mid-byte
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b0), ack);
    send_byte(8'h11, ack);
    send_byte(8'h55, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_start();
    bus_stop();
    poll(ack); check("R10 start abort leaves device idle", ack, 1);
    read_at(8'h11, 1, "R10 start abort memory");

    // R7 set the lock
    bus_start();
    send_byte(dev(4'h6, STRAP, 1'b0), ack); check("R7 lock address ack", ack, 1);
    send_byte(8'h00, ack);                  check("R7 lock byte ack", ack, 1);
    bus_stop();
    exp_lock = 1'b1;
    poll(ack); check("R7 lock starts write cycle", ack, 0);
    tick(WC + 20);
    bus_start(); send_byte(dev(4'h6, STRAP, 1'b0), ack); bus_stop();
    check("R8 lock address nack once set", ack, 0);

    // R7/R9 fully protected page
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(i ^ 8'h3C);
    do_write(8'h70, 16, "R7 protected");
    poll(ack); check("R9 no write cycle for protected transfer", ack, 1);
    read_at(8'h70, 16, "R7 protected unchanged");

    // R7 upper half still writable
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'hA0 + i);
    do_write(8'h80, 4, "R7 upper");
    poll(ack); check("R6 upper write busy", ack, 0);
    tick(WC + 20);
    read_at(8'h80, 4, "R7 upper readback");

    // R8 lock persists across all later activity
    bus_start(); send_byte(dev(4'h6, STRAP, 1'b0), ack); bus_stop();
    check("R8 lock still set", ack, 0);
    wbuf[0] = 8'h12;
    do_write(8'h05, 1, "R8 low write");
    poll(ack); check("R8 R9 low byte no cycle", ack, 1);
    read_at(8'h00, 257, "R8 final sweep");

    report();
  end
endmodule